// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `W` bits and returns the full `2W`-bit product. A grid of AND gates forms every partial product in parallel, one row for each bit of the second operand. Row `j` is the first operand gated by bit `j` of the second operand, moved up by `j` places.

The rows then pass through a linear chain of 3:2 carry-save stages. Each stage takes three vectors and returns two: a bitwise sum and a majority carry. The carry moves one place up before it feeds the next stage, and no stage ripples a carry along its width. A single carry-propagate adder at the end merges the last sum and carry vectors into the product. By default the product is captured in an output register with a synchronous, active-high reset. A parameter can select a purely combinational output instead.

Top module: `csa_array_mult`

## Requirements
- R1: With the registered output (the default), `product` equals the unsigned product of `op_a` and `op_b` sampled at the previous rising clock edge, given as `2W` bits with no truncation.
- R2: When `rst` is high at a rising edge, `product` is 0 after that edge.
- R3: When either operand is 0, `product` is 0 one cycle later.
- R4: Bit 0 of `product` equals `op_a[0] AND op_b[0]` of the previous cycle.
- R5: A single 3:2 stage given 3, 2 and 3 as 4-bit vectors returns a sum vector of 2 and a shifted carry vector of 6. Adding those two vectors gives 8.
- R6: The largest operands, both all ones, give `(2^W-1)^2`. For W=8 that is 0xFE01.
- R7: While the operands stay unchanged and reset stays low, `product` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| product | output | 2W | Unsigned product, registered by default |

## Verification
The assertions assume the registered output mode. They also assume the operands are driven to known values in every cycle after reset, because each property compares the product against the operands of the previous cycle. The stimulus changes the operands only on falling edges. It holds reset high for several cycles before any product is checked. It then covers every operand pair for the default width, and it adds a stretch in which the operands are held steady. The lone 3:2 stage is checked on its own with fixed operands, outside the multiplier.

// File: rtl/mulcsa_pkg.sv
package mulcsa_pkg;

    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } out_mode_e;

    // product width for an operand width
    function automatic int prod_width(input int w);
        return 2 * w;
    endfunction

    // number of 3:2 stages in a linear chain over w rows
    function automatic int csa_count(input int w);
        return (w > 2) ? (w - 2) : 0;
    endfunction

endpackage

// File: rtl/pp_grid.sv
module pp_grid #(
    parameter int W  = 8,
    parameter int PW = 2 * W
) (
    input  logic [W-1:0]          op_a,
    input  logic [W-1:0]          op_b,
    output logic [W-1:0][PW-1:0]  rows
);
    for (genvar j = 0; j < W; j++) begin : g_row
        logic [W-1:0] gated;
        assign gated   = op_a & {W{op_b[j]}};
        assign rows[j] = {{(PW-W){1'b0}}, gated} << j;
    end
endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    input  logic [PW-1:0] z,
    output logic [PW-1:0] sum,
    output logic [PW-1:0] carry_sh
);
    logic [PW-2:0] maj;

    always_comb begin
        sum      = x ^ y ^ z;
        maj      = (x[PW-2:0] & y[PW-2:0]) |
                   (x[PW-2:0] & z[PW-2:0]) |
                   (y[PW-2:0] & z[PW-2:0]);
        carry_sh = {maj, 1'b0};
    end
endmodule

// File: rtl/cpa_final.sv
module cpa_final #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] s_in,
    input  logic [PW-1:0] c_in,
    output logic [PW-1:0] total
);
    assign total = s_in + c_in;
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult
    import mulcsa_pkg::*;
#(
    parameter int        W    = 8,
    parameter out_mode_e MODE = STAGE_REG
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [W-1:0]               op_a,
    input  logic [W-1:0]               op_b,
    output logic [prod_width(W)-1:0]   product
);
    localparam int PW     = prod_width(W);
    localparam int NSTAGE = csa_count(W);

    typedef struct packed {
        logic [PW-1:0] sum;
        logic [PW-1:0] carry;
    } cs_pair_t;

    logic [W-1:0][PW-1:0] rows;
    cs_pair_t             chain [0:NSTAGE];
    logic [PW-1:0]        merged;

    pp_grid #(.W(W), .PW(PW)) u_grid (
        .op_a (op_a),
        .op_b (op_b),
        .rows (rows)
    );

    assign chain[0].sum   = rows[0];
    assign chain[0].carry = rows[1];

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        csa_stage #(.PW(PW)) u_csa (
            .x        (chain[k].sum),
            .y        (chain[k].carry),
            .z        (rows[k+2]),
            .sum      (chain[k+1].sum),
            .carry_sh (chain[k+1].carry)
        );
    end

    cpa_final #(.PW(PW)) u_cpa (
        .s_in  (chain[NSTAGE].sum),
        .c_in  (chain[NSTAGE].carry),
        .total (merged)
    );

    if (MODE == STAGE_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) product <= '0;
            else     product <= merged;
        end
    end else begin : g_comb
        assign product = merged;
    end
endmodule

// File: rtl/csa_array_mult_chk.sv
module csa_array_mult_chk
    import mulcsa_pkg::*;
#(
    parameter int        W    = 8,
    parameter out_mode_e MODE = STAGE_REG
) (
    input logic                 clk,
    input logic                 rst,
    input logic [W-1:0]         op_a,
    input logic [W-1:0]         op_b,
    input logic [2*W-1:0]       product
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] OPMAX = {{W{1'b0}}, {W{1'b1}}};
    localparam logic [PW-1:0] PMAX  = OPMAX * OPMAX;

    if (MODE == STAGE_REG) begin : g_reg
        // R2
        p_reset_clear_r2: assert property (@(posedge clk)
            rst |=> (product == '0));

        // R1
        p_exact_product_r1: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (product == ({{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)})));

        // R3
        p_zero_operand_r3: assert property (@(posedge clk) disable iff (rst)
            ((op_a == '0) || (op_b == '0)) |=> (product == '0));

        // R4
        p_low_bit_r4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (product[0] == ($past(op_a[0]) & $past(op_b[0]))));

        // R6
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (product <= PMAX));

        // R7
        p_hold_steady_r7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(op_a) && $stable(op_b)) |=> $stable(product));
    end else begin : g_comb
        // R1 (combinational variant)
        p_exact_product_r1: assert property (@(posedge clk) disable iff (rst)
            product == ({{W{1'b0}}, op_a} * {{W{1'b0}}, op_b}));
    end
endmodule

bind csa_array_mult csa_array_mult_chk #(.W(W), .MODE(MODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/csa_array_mult_bench.sv
module csa_array_mult_bench;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    csa_array_mult #(.W(W)) u_csa_array_mult (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    // standalone 3:2 stage for the carry-save case
    logic [3:0] cs_x = 4'd3, cs_y = 4'd2, cs_z = 4'd3;
    logic [3:0] cs_sum, cs_car;
    csa_stage #(.PW(4)) u_csa_unit (
        .x (cs_x), .y (cs_y), .z (cs_z),
        .sum (cs_sum), .carry_sh (cs_car)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference, one register deep
    logic [W-1:0]  p_a, p_b, pp_a, pp_b;
    logic          p_rst = 1'b1, pp_rst = 1'b1;
    logic [PW-1:0] exp_q, last_prod;
    int            edges = 0;

    always @(posedge clk) begin
        pp_a   <= p_a;   pp_b   <= p_b;   pp_rst <= p_rst;
        p_a    <= op_a;  p_b    <= op_b;  p_rst  <= rst;
        exp_q  <= rst ? '0 : PW'(longint'(op_a) * longint'(op_b));
        edges  <= edges + 1;
    end

    always @(negedge clk) begin
        if (edges >= 1) begin
            string tag;
            if (p_rst)                            tag = "R2";
            else if (p_a == '0 || p_b == '0)      tag = "R3";
            else if (&p_a && &p_b)                tag = "R6";
            else                                  tag = "R1";
            check(product == exp_q, tag, product, exp_q);
            if (!p_rst)
                check(product[0] == (p_a[0] & p_b[0]), "R4", product[0], p_a[0] & p_b[0]);
            if (edges >= 2 && !p_rst && !pp_rst && p_a == pp_a && p_b == pp_b)
                check(product == last_prod, "R7", product, last_prod);
        end
        last_prod = product;
    end

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: carry-save of 3, 2, 3
        check(cs_sum == 4'd2, "R5", cs_sum, 2);
        check(cs_car == 4'd6, "R5", cs_car, 6);
        check(4'(cs_sum + cs_car) == 4'd8, "R5", 4'(cs_sum + cs_car), 8);
        rst = 1'b0;
        drive(8'd0, 8'd77);      // R3
        drive(8'd91, 8'd0);      // R3
        drive(8'hFF, 8'hFF);     // R6
        @(negedge clk);
        check(product == 16'hFE01, "R6", product, 16'hFE01);
        drive(8'd3, 8'd3);
        drive(8'd1, 8'd1);
        drive(8'd128, 8'd2);
        // R7: hold operands steady
        drive(8'd200, 8'd77);
        repeat (4) @(negedge clk);
        // R2: reset in the middle of traffic
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        // R1: every operand pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                drive(W'(a), W'(b));
            end
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule